// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferred Credits

This block decides when a memory controller sends refresh commands to a DRAM. A free-running interval timer, clocked by the system clock, expires once per average refresh spacing. That spacing is the 64 ms retention window divided by the 8,192 rows, which is 7.8125 µs. Each expiry adds one credit to a counter of owed refreshes. While normal traffic keeps the memory busy, credits pile up instead of stalling traffic. The backlog is capped at `MAX_POSTPONE`. When the cap is reached, the block marks the backlog urgent and blocks normal accesses so that the memory drains and the refresh can go out.

The refresh request is a valid/ready pair, `ref_req` and `ref_ack`. A transfer happens on a rising clock edge where both are high. Once `ref_req` is raised it is held until that transfer, whatever `mem_idle` does in the meantime. The controller may hold `ref_ack` low for as long as it needs. Each transfer costs one credit and opens a refresh window of `TRFC` cycles. During the window `access_block` is high and no new request is raised.

The DRAM picks the refreshed row with its own counter, which advances by one per refresh. The block keeps a copy of that counter, advances it on each transfer, wraps it from `ROWS-1` to 0, and reports it on `row_idx`.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous active-low reset sets `ref_req`, `access_block`, `urgent`, `pend_cnt`, `row_idx` and the interval timer to 0.
- R2: With no transfer taking place, `pend_cnt` rises by one on every `INTERVAL_CYC`-th clock edge after reset is released (edges `INTERVAL_CYC`, 2·`INTERVAL_CYC`, ...).
- R3: `pend_cnt` never exceeds `MAX_POSTPONE`. A timer expiry at the cap adds nothing. `urgent` is high exactly when `pend_cnt` equals `MAX_POSTPONE`.
- R4: `ref_req` rises on the clock edge after a cycle in which `pend_cnt` is nonzero, no refresh window is open and `mem_idle` or `urgent` is high. It stays low while `pend_cnt` is 0.
- R5: Once high, `ref_req` stays high until a cycle in which `ref_ack` is also high, and falls on that edge.
- R6: Each transfer lowers `pend_cnt` by one. A transfer and a timer expiry on the same edge leave `pend_cnt` unchanged. `ref_ack` has no effect while `ref_req` is low.
- R7: After a transfer, `access_block` is high for exactly `TRFC` cycles, starting on the following edge. `ref_req` stays low throughout that window.
- R8: `row_idx` advances by one on each transfer and wraps from `ROWS-1` to 0. It changes at no other time.
- R9: `access_block` is high whenever `urgent` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_idle | input | 1 | No normal access is waiting or in flight |
| ref_ack | input | 1 | Command interface accepts the refresh request (ready) |
| ref_req | output | 1 | Refresh request (valid), held until accepted |
| access_block | output | 1 | Normal reads and writes must not be issued |
| urgent | output | 1 | Backlog is at its cap |
| pend_cnt | output | $clog2(MAX_POSTPONE+1) | Refreshes owed |
| row_idx | output | $clog2(ROWS) | Mirror of the device's refresh row counter |

## Verification
Properties are checked on every cycle:
- the backlog cap;
- the credit arithmetic on timer expiries and on transfers;
- that a request is held until it is accepted;
- that no request appears inside a refresh window;
- that blocking follows urgency;
- that the row copy steps and wraps.

Some behaviours depend on the exact cycle at which things happen, and only the bench's scenarios show them:
- the timer period;
- saturation under sustained traffic;
- a transfer and an expiry landing on the same edge;
- the exact length of the window;
- a reset in the middle of operation.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // Width needed to hold values 0..n (never below 1)
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned INTERVAL_CYC = 976
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned TW = refresh_pkg::width_for(INTERVAL_CYC);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: the count never runs past the period
  assert_timer_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/refresh_credit.sv
module refresh_credit #(
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic taken,
  output logic [refresh_pkg::width_for(MAX_POSTPONE)-1:0] pend,
  output logic at_cap
);
  localparam int unsigned PW = refresh_pkg::width_for(MAX_POSTPONE);
  localparam logic [PW-1:0] CAP = PW'(MAX_POSTPONE);

  logic add;

  assign at_cap = (pend == CAP);
  assign add    = tick && !at_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else begin
      case ({add, taken})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CAP);
  assert_credit_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !taken && pend != CAP) |=> pend == $past(pend) + 1'b1);
  assert_credit_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !tick) |=> pend == $past(pend) - 1'b1);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> pend != '0);
endmodule

// File: rtl/refresh_window.sv
module refresh_window #(
  parameter int unsigned TRFC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int unsigned FW = refresh_pkg::width_for(TRFC);

  logic [FW-1:0] left;

  assign active = (left != '0);
  assign last   = (left == FW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      left <= '0;
    else if (start)  left <= FW'(TRFC);
    else if (active) left <= left - 1'b1;
  end

  assert_window_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> left == FW'(TRFC));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);
endmodule

// File: rtl/row_mirror.sv
module row_mirror #(
  parameter int unsigned ROWS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam logic [RW-1:0] TOP = RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= (row == TOP) ? '0 : row + 1'b1;
  end

  assert_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row == (($past(row) == TOP) ? '0 : $past(row) + 1'b1));
  assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned INTERVAL_CYC = CLK_MHZ * 78125 / 10000,
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned TRFC         = 16,
  parameter int unsigned ROWS         = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_idle,
  input  logic ref_ack,
  output logic ref_req,
  output logic access_block,
  output logic urgent,
  output logic [refresh_pkg::width_for(MAX_POSTPONE)-1:0] pend_cnt,
  output logic [$clog2(ROWS)-1:0] row_idx
);
  logic tick, xfer, win_active, win_last, may_raise;

  assign xfer = ref_req && ref_ack;

  refresh_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  refresh_credit #(.MAX_POSTPONE(MAX_POSTPONE)) u_credit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .taken(xfer),
    .pend(pend_cnt), .at_cap(urgent));

  refresh_window #(.TRFC(TRFC)) u_window (
    .clk(clk), .rst_n(rst_n), .start(xfer),
    .active(win_active), .last(win_last));

  row_mirror #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .step(xfer), .row(row_idx));

  assign may_raise    = (pend_cnt != '0) && !win_active && (mem_idle || urgent);
  assign access_block = win_active || urgent;

  // Valid is registered and held until the transfer edge
  always_ff @(posedge clk) begin
    if (!rst_n)       ref_req <= 1'b0;
    else if (ref_req) ref_req <= !ref_ack;
    else              ref_req <= may_raise;
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);
  assert_req_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> !ref_req);
  assert_req_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0) |-> !ref_req);
  assert_urgent_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> access_block);
  assert_window_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !urgent) |=> !access_block);
endmodule

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  localparam int unsigned IV = 10, MAXP = 3, TR = 4, NR = 4;
  localparam int unsigned PW = refresh_pkg::width_for(MAXP);
  localparam int unsigned RW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0, mem_idle = 1'b0, ref_ack = 1'b0;
  logic ref_req, access_block, urgent;
  logic [PW-1:0] pend_cnt;
  logic [RW-1:0] row_idx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  refresh_sched #(.INTERVAL_CYC(IV), .MAX_POSTPONE(MAXP), .TRFC(TR), .ROWS(NR)) i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .mem_idle(mem_idle), .ref_ack(ref_ack),
    .ref_req(ref_req), .access_block(access_block), .urgent(urgent),
    .pend_cnt(pend_cnt), .row_idx(row_idx));

  typedef struct packed {
    logic [7:0] n;
    logic idle, ack, req, blk, urg;
    logic [3:0] pend;
    logic [3:0] row;
  } vec_t;

  localparam int NV = 18;
  // idle/ack are held for n cycles; outputs are checked after the last edge
  localparam vec_t VEC [NV] = '{
    '{8'd9,  1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd0,4'd0},
    '{8'd1,  1'b0,1'b0, 1'b0,1'b0,1'b0, 4'd1,4'd0},
    '{8'd20, 1'b0,1'b0, 1'b0,1'b1,1'b1, 4'd3,4'd0},
    '{8'd10, 1'b0,1'b0, 1'b1,1'b1,1'b1, 4'd3,4'd0},
    '{8'd1,  1'b0,1'b1, 1'b0,1'b1,1'b0, 4'd2,4'd1},
    '{8'd3,  1'b1,1'b0, 1'b0,1'b1,1'b0, 4'd2,4'd1},
    '{8'd1,  1'b1,1'b0, 1'b0,1'b0,1'b0, 4'd2,4'd1},
    '{8'd1,  1'b1,1'b0, 1'b1,1'b0,1'b0, 4'd2,4'd1},
    '{8'd3,  1'b0,1'b0, 1'b1,1'b0,1'b0, 4'd2,4'd1},
    '{8'd1,  1'b0,1'b1, 1'b0,1'b1,1'b0, 4'd2,4'd2},
    '{8'd4,  1'b1,1'b0, 1'b0,1'b0,1'b0, 4'd2,4'd2},
    '{8'd1,  1'b1,1'b0, 1'b1,1'b0,1'b0, 4'd2,4'd2},
    '{8'd1,  1'b1,1'b1, 1'b0,1'b1,1'b0, 4'd1,4'd3},
    '{8'd5,  1'b1,1'b0, 1'b1,1'b0,1'b0, 4'd2,4'd3},
    '{8'd1,  1'b1,1'b1, 1'b0,1'b1,1'b0, 4'd1,4'd0},
    '{8'd5,  1'b1,1'b1, 1'b1,1'b0,1'b0, 4'd1,4'd0},
    '{8'd1,  1'b1,1'b1, 1'b0,1'b1,1'b0, 4'd0,4'd1},
    '{8'd10, 1'b1,1'b0, 1'b1,1'b0,1'b0, 4'd1,4'd1}
  };
  localparam string TAG [NV] = '{
    "R2", "R2", "R3/R9", "R3/R4", "R6", "R7", "R7", "R4", "R5",
    "R6", "R7", "R4", "R6", "R2", "R8", "R4", "R6", "R2"};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int req, input int blk,
                           input int urg, input int pend, input int row);
    check(tag, "ref_req", int'(ref_req), req);
    check(tag, "access_block", int'(access_block), blk);
    check(tag, "urgent", int'(urgent), urg);
    check(tag, "pend_cnt", int'(pend_cnt), pend);
    check(tag, "row_idx", int'(row_idx), row);
  endtask

  initial begin
    repeat (3) step();
    check_all("R1 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      mem_idle = VEC[i].idle;
      ref_ack  = VEC[i].ack;
      repeat (int'(VEC[i].n)) step();
      check_all(TAG[i], int'(VEC[i].req), int'(VEC[i].blk), int'(VEC[i].urg),
                int'(VEC[i].pend), int'(VEC[i].row));
    end
    // R1: reset in the middle of operation
    rst_n = 1'b0;
    step();
    check_all("R1 mid-run reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    // R6: acknowledge with no request pending changes nothing
    mem_idle = 1'b1;
    ref_ack  = 1'b1;
    repeat (3) step();
    check_all("R6 stray ack", 0, 0, 0, 0, 0);
    // R2: first credit after reset lands exactly on edge IV
    ref_ack = 1'b0;
    repeat (IV - 4) step();
    check("R2 edge IV-1", "pend_cnt", int'(pend_cnt), 0);
    step();
    check("R2 edge IV", "pend_cnt", int'(pend_cnt), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule